// File: doc/BRIEF.md
# Processor Priority Mapper

This block works next to a hardware real-time scheduler in a multiprocessor system on chip. For each processor it gets the priority of the task that processor is running, or a flag saying the processor is idle. It turns these relative task priorities into absolute processor priorities. Each processor gets a different rank from 0 to N-1, and the ranks keep the order of the running tasks. The ranks feed a bus arbiter, so a processor running a more urgent task also wins the shared bus. This prevents priority inversion caused by fixed processor priorities.

The scheduler pulses a per-processor update strobe whenever that processor's running task changes. The block captures the strobed inputs and re-ranks every processor on the next cycle. It then sends only the ranks that changed to the arbiter over a narrow priority bus, one write per cycle. Each write carries a processor index and its new rank. The block holds a busy flag while a re-rank or any write is outstanding.

Top module: `cpu_prio_mapper`

## Requirements
- R1: After reset, no write is issued and busy is low. Every processor is treated as idle, so processor i holds rank N-1-i, which the arbiter must also assume at reset.
- R2: Rank is a number from 0 to N-1, and N-1 is the highest. Among running processors, a larger task priority value gives a strictly higher rank.
- R3: When two processors have equal task priority and the same running state, the one with the lower index gets the higher rank.
- R4: An idle processor (run flag 0) ranks below every running processor, whatever its priority input.
- R5: The ranks of all processors always form a permutation of 0..N-1, and every write carries an index and a rank below N.
- R6: Only the inputs of processors whose strobe is high are captured. Changes on an unstrobed processor's inputs have no effect on any rank.
- R7: A write is issued only for a processor whose new rank differs from the rank last written for it. There is at most one write per cycle, and within one re-rank the writes go in ascending processor index.
- R8: A strobe sampled at clock edge k makes busy high in the following cycle. The first write of the resulting re-rank is valid in the cycle after edge k+1.
- R9: Busy is high whenever a write is valid. With nothing pending and no strobe, busy stays low.
- R10: A strobe arriving while writes are still pending starts a new re-rank. Once busy falls, the arbiter's view matches the ranks of the latest captured inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| task_prio_i | input | NUM_CPU*PRIO_W | Priority of the task running on each processor; processor i uses bits [i*PRIO_W +: PRIO_W], and a larger value means more urgent |
| run_i | input | NUM_CPU | 1 when the processor is executing a task, 0 when idle |
| upd_i | input | NUM_CPU | Per-processor strobe: capture this processor's inputs and re-rank |
| pbus_vld_o | output | 1 | Priority bus write valid |
| pbus_idx_o | output | IDX_W | Processor index of the write |
| pbus_rank_o | output | IDX_W | New rank of that processor |
| busy_o | output | 1 | Re-rank or writes outstanding |

## Verification
The bench aims at ties between equal task priorities and at mixes of idle and running processors. A design that got these wrong would give two processors the same rank or let an idle processor outrank a working one. It changes inputs without a strobe, which would catch a design that samples live inputs instead of captured ones. It sends strobes in the middle of a write burst, where a design that keeps a stale target would leave the arbiter with old ranks. It also counts and orders the writes of each burst, which catches unchanged ranks being resent, writes being lost, or a first write arriving a cycle early or late.

// File: rtl/cpu_prio_pkg.sv
package cpu_prio_pkg;
    parameter int unsigned DEF_NUM_CPU = 3;
    parameter int unsigned DEF_PRIO_W  = 8;

    // index width that stays at least one bit wide
    function automatic int unsigned idx_width(int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/cpu_prio_rank.sv
module cpu_prio_rank #(
    parameter int unsigned N  = 3,
    parameter int unsigned PW = 8,
    parameter int unsigned IW = 2
) (
    input  logic [N-1:0][PW-1:0] prio,
    input  logic [N-1:0]         run,
    output logic [N-1:0][IW-1:0] rank
);
    // rank of a processor = number of processors it outranks
    for (genvar i = 0; i < N; i++) begin : g_row
        always_comb begin
            logic [IW-1:0] cnt;
            logic [PW:0]   key_i;
            logic [PW:0]   key_j;
            cnt   = '0;
            key_i = {run[i], prio[i]};
            for (int j = 0; j < N; j++) begin
                key_j = {run[j], prio[j]};
                if (j != i) begin
                    if ((key_i > key_j) || ((key_i == key_j) && (i < j))) begin
                        cnt = cnt + IW'(1);
                    end
                end
            end
            rank[i] = cnt;
        end
    end
endmodule

// File: rtl/cpu_prio_pick.sv
module cpu_prio_pick #(
    parameter int unsigned N  = 3,
    parameter int unsigned IW = 2
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx,
    output logic [N-1:0]  onehot
);
    always_comb begin
        any    = |req;
        idx    = '0;
        onehot = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx    = IW'(i);
                onehot = N'(1) << i;
            end
        end
    end
endmodule

// File: rtl/cpu_prio_mapper.sv
module cpu_prio_mapper
    import cpu_prio_pkg::*;
#(
    parameter int unsigned NUM_CPU = DEF_NUM_CPU,
    parameter int unsigned PRIO_W  = DEF_PRIO_W,
    localparam int unsigned IDX_W  = idx_width(NUM_CPU)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_CPU*PRIO_W-1:0] task_prio_i,
    input  logic [NUM_CPU-1:0]        run_i,
    input  logic [NUM_CPU-1:0]        upd_i,
    output logic                      pbus_vld_o,
    output logic [IDX_W-1:0]          pbus_idx_o,
    output logic [IDX_W-1:0]          pbus_rank_o,
    output logic                      busy_o
);
    typedef struct packed {
        logic [NUM_CPU-1:0][PRIO_W-1:0] cap_prio;
        logic [NUM_CPU-1:0]             cap_run;
        logic                           rerank;
        logic [NUM_CPU-1:0][IDX_W-1:0]  sent;
        logic [NUM_CPU-1:0][IDX_W-1:0]  target;
        logic [NUM_CPU-1:0]             pend;
    } state_t;

    function automatic state_t reset_state();
        state_t s;
        s = '0;
        for (int i = 0; i < NUM_CPU; i++) begin
            s.sent[i]   = IDX_W'(NUM_CPU - 1 - i);
            s.target[i] = IDX_W'(NUM_CPU - 1 - i);
        end
        return s;
    endfunction

    state_t st_d, st_q;

    logic [NUM_CPU-1:0][PRIO_W-1:0] prio_in;
    logic [NUM_CPU-1:0][IDX_W-1:0]  rank_w;
    logic                           pick_any;
    logic [IDX_W-1:0]               pick_idx;
    logic [NUM_CPU-1:0]             pick_oh;

    for (genvar i = 0; i < NUM_CPU; i++) begin : g_unpack
        assign prio_in[i] = task_prio_i[i*PRIO_W +: PRIO_W];
    end

    cpu_prio_rank #(.N(NUM_CPU), .PW(PRIO_W), .IW(IDX_W)) rank_i (
        .prio (st_q.cap_prio),
        .run  (st_q.cap_run),
        .rank (rank_w)
    );

    cpu_prio_pick #(.N(NUM_CPU), .IW(IDX_W)) pick_i (
        .req    (st_q.pend),
        .any    (pick_any),
        .idx    (pick_idx),
        .onehot (pick_oh)
    );

    always_comb begin
        st_d = st_q;
        // capture strobed inputs only
        for (int i = 0; i < NUM_CPU; i++) begin
            if (upd_i[i]) begin
                st_d.cap_prio[i] = prio_in[i];
                st_d.cap_run[i]  = run_i[i];
            end
        end
        st_d.rerank = |upd_i;
        // one write per cycle
        if (pick_any) begin
            st_d.sent[pick_idx] = st_q.target[pick_idx];
        end
        st_d.pend = st_q.pend & ~pick_oh;
        // fresh ranking replaces any older pending set
        if (st_q.rerank) begin
            st_d.target = rank_w;
            for (int i = 0; i < NUM_CPU; i++) begin
                st_d.pend[i] = (rank_w[i] != st_d.sent[i]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= reset_state();
        end else begin
            st_q <= st_d;
        end
    end

    assign pbus_vld_o  = pick_any;
    assign pbus_idx_o  = pick_idx;
    assign pbus_rank_o = st_q.target[pick_idx];
    assign busy_o      = st_q.rerank | pick_any;
endmodule

// File: rtl/cpu_prio_mapper_chk.sv
module cpu_prio_mapper_chk #(
    parameter int unsigned NUM_CPU = 3,
    parameter int unsigned IDX_W   = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_CPU-1:0] upd_i,
    input logic               pbus_vld_o,
    input logic [IDX_W-1:0]   pbus_idx_o,
    input logic [IDX_W-1:0]   pbus_rank_o,
    input logic               busy_o
);
    p_vld_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pbus_vld_o |-> busy_o);

    p_quiet_stays_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !(|upd_i)) |=> !busy_o);

    p_strobe_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|upd_i) |=> busy_o);

    p_first_write_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((|upd_i) && !busy_o) |=> !pbus_vld_o);

    p_idx_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pbus_vld_o |-> (int'(pbus_idx_o) < NUM_CPU));

    p_rank_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pbus_vld_o |-> (int'(pbus_rank_o) < NUM_CPU));
endmodule

bind cpu_prio_mapper cpu_prio_mapper_chk #(.NUM_CPU(NUM_CPU), .IDX_W(IDX_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .upd_i       (upd_i),
    .pbus_vld_o  (pbus_vld_o),
    .pbus_idx_o  (pbus_idx_o),
    .pbus_rank_o (pbus_rank_o),
    .busy_o      (busy_o)
);

// File: tb/cpu_prio_mapper_tb_top.sv
`timescale 1ns/1ps
module cpu_prio_mapper_tb_top;
    localparam int N  = 3;
    localparam int PW = 8;
    localparam int IW = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N*PW-1:0] task_prio;
    logic [N-1:0]    run;
    logic [N-1:0]    upd;
    logic            vld;
    logic [IW-1:0]   idx;
    logic [IW-1:0]   rnk;
    logic            busy;

    logic [PW-1:0] d_prio [N];
    logic          d_run  [N];

    int m_prio [N];
    int m_run  [N];
    int m_sent [N];
    int snap   [N];
    int wr_log [64];
    int wr_cnt;
    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            task_prio[i*PW +: PW] = d_prio[i];
            run[i] = d_run[i];
        end
    end

    cpu_prio_mapper #(.NUM_CPU(N), .PRIO_W(PW)) dut_i (
        .clk(clk), .rst_n(rst_n), .task_prio_i(task_prio), .run_i(run), .upd_i(upd),
        .pbus_vld_o(vld), .pbus_idx_o(idx), .pbus_rank_o(rnk), .busy_o(busy)
    );

    // arbiter-side view built from observed writes
    always @(negedge clk) begin
        if (rst_n && vld) begin
            if (int'(idx) < N) m_sent[idx] = int'(rnk);
            if (wr_cnt < 64) wr_log[wr_cnt] = int'(idx);
            wr_cnt = wr_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_rank(int i);
        int c = 0;
        int ki = (m_run[i] << PW) | m_prio[i];
        for (int j = 0; j < N; j++) begin
            int kj = (m_run[j] << PW) | m_prio[j];
            if (j != i && (ki > kj || (ki == kj && i < j))) c++;
        end
        return c;
    endfunction

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    task automatic strobe(input logic [N-1:0] mask);
        @(negedge clk);
        for (int i = 0; i < N; i++) begin
            if (mask[i]) begin
                m_prio[i] = int'(d_prio[i]);
                m_run[i]  = int'(d_run[i]);
            end
        end
        upd = mask;
        @(negedge clk);
        upd = '0;
    endtask

    task automatic wait_idle();
        int guard = 0;
        while (busy && guard < 100) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic settle_check(input string tag, input bit count_writes);
        int want = 0;
        bit perm_ok = 1'b1;
        int seen = 0;
        wait_idle();
        for (int i = 0; i < N; i++) begin
            chk(m_sent[i] == exp_rank(i), tag, m_sent[i], exp_rank(i));
            if (m_sent[i] != snap[i]) want++;
            seen |= (1 << m_sent[i]);
        end
        if (seen != (1 << N) - 1) perm_ok = 1'b0;
        chk(perm_ok, "R5 permutation", seen, (1 << N) - 1);
        if (count_writes) begin
            want = 0;
            for (int i = 0; i < N; i++) if (exp_rank(i) != snap[i]) want++;
            chk(wr_cnt == want, "R7 write count", wr_cnt, want);
            for (int k = 1; k < wr_cnt && k < 64; k++)
                chk(wr_log[k] > wr_log[k-1], "R7 ascending order", wr_log[k], wr_log[k-1] + 1);
        end
    endtask

    task automatic begin_burst();
        for (int i = 0; i < N; i++) snap[i] = m_sent[i];
        wr_cnt = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed_0017));
        upd = '0;
        wr_cnt = 0;
        for (int i = 0; i < N; i++) begin
            d_prio[i] = '0; d_run[i] = 1'b0;
            m_prio[i] = 0; m_run[i] = 0; m_sent[i] = N - 1 - i;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: quiet after reset
        repeat (4) begin
            @(negedge clk);
            chk(!busy, "R1 busy after reset", busy, 0);
            chk(!vld, "R1 no write after reset", vld, 0);
        end
        chk(wr_cnt == 0, "R1 write count", wr_cnt, 0);

        // R8: timing; cpu2 running moves all three ranks
        begin_burst();
        d_run[2] = 1'b1; d_prio[2] = 8'd5;
        @(negedge clk);
        m_run[2] = 1; m_prio[2] = 5;
        upd = 3'b100;
        @(negedge clk);
        upd = '0;
        chk(busy, "R8 busy after strobe", busy, 1);
        chk(!vld, "R8 no write yet", vld, 0);
        @(negedge clk);
        chk(vld && idx == 0 && rnk == 1, "R8 first write cpu0 rank1", {vld, idx, rnk}, {1'b1, 2'd0, 2'd1});
        @(negedge clk);
        chk(vld && idx == 1 && rnk == 0, "R7 second write cpu1 rank0", {vld, idx, rnk}, {1'b1, 2'd1, 2'd0});
        @(negedge clk);
        chk(vld && idx == 2 && rnk == 2, "R7 third write cpu2 rank2", {vld, idx, rnk}, {1'b1, 2'd2, 2'd2});
        @(negedge clk);
        chk(!busy && !vld, "R9 idle after burst", busy, 0);
        settle_check("R2 timing case ranks", 1'b1);

        // R3: all running, equal priority
        begin_burst();
        for (int i = 0; i < N; i++) begin d_run[i] = 1'b1; d_prio[i] = 8'd7; end
        strobe('1);
        settle_check("R3 tie by index", 1'b1);
        chk(m_sent[0] == 2 && m_sent[2] == 0, "R3 cpu0 top cpu2 bottom", m_sent[0], 2);

        // R4: idle cpu0 with large priority input, others running at 0
        begin_burst();
        d_run[0] = 1'b0; d_prio[0] = 8'hff;
        d_prio[1] = 8'd0; d_prio[2] = 8'd0;
        strobe('1);
        settle_check("R4 idle lowest", 1'b1);
        chk(m_sent[0] == 0, "R4 idle cpu0 rank", m_sent[0], 0);

        // R6: unstrobed change ignored
        begin_burst();
        d_prio[2] = 8'd200;          // not strobed
        d_prio[0] = 8'd1;            // cpu0 still idle, strobed
        strobe(3'b001);
        settle_check("R6 unstrobed ignored", 1'b1);
        chk(m_sent[2] == 1, "R6 cpu2 rank unchanged", m_sent[2], 1);

        // R10: strobe in the middle of writes
        d_prio[2] = 8'd0;
        d_run[0] = 1'b1; d_prio[0] = 8'd9;
        strobe(3'b001);
        @(negedge clk);
        d_run[1] = 1'b0; d_run[2] = 1'b1; d_prio[2] = 8'd50;
        strobe(3'b110);
        for (int i = 0; i < N; i++) snap[i] = m_sent[i];
        settle_check("R10 restrobe final view", 1'b0);

        // random with many ties; some strobes land mid-burst
        for (int it = 0; it < 400; it++) begin
            bit back_to_back = ($urandom % 4) == 0;
            logic [N-1:0] mask = N'($urandom);
            if (mask == '0) mask = 1;
            for (int i = 0; i < N; i++) begin
                d_prio[i] = PW'($urandom % 4);
                d_run[i]  = ($urandom % 4) != 0;
            end
            if (!back_to_back) wait_idle();
            begin_burst();
            strobe(mask);
            if (!back_to_back) settle_check("R2 random ranks", 1'b1);
        end
        settle_check("R10 random final", 1'b0);

        finish_run();
    end
endmodule